// File: doc/BRIEF.md
# Indirect Interrupt Level Driver

This block holds one level register per processor interrupt line and lets software set any one of them through a single shared register. A store to that register carries two bytes. The byte at the lower address names the target line, and the byte at the next address gives the level to place on that line. The addressed line takes the new level and keeps it until a later store changes it. Every other line keeps its current value.

Each line therefore behaves as a steady level source for a level-sensitive interrupt input. A multi-bit level vector is provided, together with a one-bit-per-line request output. The number of lines, the level width and the register's offset are parameters. The write port is a plain bus interface with a byte address, two byte lanes and a 16-bit data word. The word is big-endian: `wr_data[15:8]` is the byte at the even address.

Top module: `irq_level_drv`

## Requirements
- R1: While reset is held and on the first cycle after it, every line's level and every request bit is 0.
- R2: A write with both lanes enabled (`wr_be`=2'b11) whose address has the same bits above bit 0 as REG_OFFSET (default 8) sets the line numbered by `wr_data[15:8]` to the level in `wr_data[7:0]`. For example, data 0x0102 puts level 2 on line 1. The new value is visible on the cycle after the write edge.
- R3: A write at the register with only the even-address lane enabled (`wr_be`=2'b10) sets the named line to level 0.
- R4: A line keeps its level across any number of cycles and across writes that name other lines.
- R5: A write that names a line number equal to or greater than NPORT changes no output.
- R6: A write to any address whose bits above bit 0 differ from REG_OFFSET's, or any cycle with `wr_en` low, changes no output.
- R7: A write with only the odd-address lane enabled (`wr_be`=2'b01) carries no line number and changes no output.
- R8: `irq_out[i]` is 1 exactly when line i's level is nonzero.
- R9: The stored level is the low LVL_W bits of the level byte. Higher bits are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Byte address within the block window |
| wr_be | input | 2 | Lane enables: bit 1 = even-address byte, bit 0 = odd-address byte |
| wr_data | input | 16 | Big-endian write data: [15:8] line number, [7:0] level |
| lvl_out | output | NPORT*LVL_W | Held level of line i at bits [i*LVL_W +: LVL_W] |
| irq_out | output | NPORT | Per-line request, set when the line's level is nonzero |

## Verification
Each line's level is a register that drives a port directly, so a faulty select or load appears on `lvl_out` one cycle after the write that caused it. A decode fault affects other lines as well. A stray load shows up as a changed level on a line the write did not name. A missed load shows up as a stale level on the named line. The bench sweeps every line number up to twice NPORT against every level up to twice the level range, then compares the whole output vector after every write. This exposes both kinds of fault at once, as well as truncation faults. A held-value fault cannot hide for more than one write.

// File: rtl/ild_pkg.sv
`timescale 1ns/1ps
package ild_pkg;

  localparam int unsigned BYTE_W = 8;

  // line number lives in the even-address byte of the big-endian word
  function automatic logic [BYTE_W-1:0] word_line(input logic [15:0] d);
    return d[15:8];
  endfunction

  // level comes from the odd-address byte; absent lane means level zero
  function automatic logic [BYTE_W-1:0] word_level(input logic [15:0] d,
                                                   input logic [1:0]  be);
    return be[0] ? d[7:0] : '0;
  endfunction

  function automatic logic line_in_range(input logic [BYTE_W-1:0] line,
                                         input int unsigned n);
    return 32'(line) < n;
  endfunction

endpackage

// File: rtl/ild_decode.sv
`timescale 1ns/1ps
module ild_decode
  import ild_pkg::*;
#(
  parameter int unsigned NPORT      = 4,
  parameter int unsigned ADDR_W     = 6,
  parameter int unsigned REG_OFFSET = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [1:0]        wr_be,
  input  logic [15:0]       wr_data,
  output logic              cmd_hit,
  output logic [BYTE_W-1:0] cmd_line,
  output logic [BYTE_W-1:0] cmd_level,
  output logic [NPORT-1:0]  sel_vec
);
  localparam int unsigned OFF_WORD = REG_OFFSET / 2;

  logic addr_match;
  logic unused_a0;

  assign unused_a0  = wr_addr[0];
  assign addr_match = (wr_addr[ADDR_W-1:1] == (ADDR_W-1)'(OFF_WORD));
  assign cmd_hit    = wr_en && wr_be[1] && addr_match;
  assign cmd_line   = word_line(wr_data);
  assign cmd_level  = word_level(wr_data, wr_be);

  for (genvar i = 0; i < NPORT; i++) begin : g_sel
    assign sel_vec[i] = cmd_hit && (cmd_line == BYTE_W'(i));
  end

  // R5: an out-of-range line number selects nothing
  p_oor_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_hit && !line_in_range(cmd_line, NPORT)) |-> (sel_vec == '0));

  // R3: a single-lane store carries level zero
  p_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_hit && !wr_be[0]) |-> (cmd_level == '0));

  // R4: at most one line is loaded per write
  p_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_vec));

endmodule

// File: rtl/ild_line.sv
`timescale 1ns/1ps
module ild_line #(
  parameter int unsigned LVL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic [LVL_W-1:0] lvl_in,
  output logic [LVL_W-1:0] level_q,
  output logic             irq
);
  always_ff @(posedge clk) begin
    if (!rst_n)   level_q <= '0;
    else if (sel) level_q <= lvl_in;
  end

  assign irq = |level_q;

  // R2: a selected line takes the presented level
  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sel |=> (level_q == $past(lvl_in)));

  // R4: an unselected line holds its level
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> $stable(level_q));

endmodule

// File: rtl/irq_level_drv.sv
`timescale 1ns/1ps
module irq_level_drv
  import ild_pkg::*;
#(
  parameter int unsigned NPORT      = 4,
  parameter int unsigned LVL_W      = 8,
  parameter int unsigned ADDR_W     = 6,
  parameter int unsigned REG_OFFSET = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [1:0]             wr_be,
  input  logic [15:0]            wr_data,
  output logic [NPORT*LVL_W-1:0] lvl_out,
  output logic [NPORT-1:0]       irq_out
);
  localparam int unsigned OFF_WORD = REG_OFFSET / 2;

  logic              cmd_hit;
  logic [BYTE_W-1:0] cmd_line;
  logic [BYTE_W-1:0] cmd_level;
  logic [NPORT-1:0]  sel_vec;
  logic [LVL_W-1:0]  lvl_trunc;
  logic              unused_lvl;

  ild_decode #(
    .NPORT(NPORT), .ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_be(wr_be), .wr_data(wr_data), .cmd_hit(cmd_hit),
    .cmd_line(cmd_line), .cmd_level(cmd_level), .sel_vec(sel_vec)
  );

  // R9: keep the low LVL_W bits of the level byte
  assign lvl_trunc  = cmd_level[LVL_W-1:0];
  assign unused_lvl = ^{cmd_level, cmd_hit, cmd_line};

  for (genvar i = 0; i < NPORT; i++) begin : g_line
    ild_line #(.LVL_W(LVL_W)) u_line (
      .clk(clk), .rst_n(rst_n), .sel(sel_vec[i]), .lvl_in(lvl_trunc),
      .level_q(lvl_out[i*LVL_W +: LVL_W]), .irq(irq_out[i])
    );
  end

  // R1: reset clears all lines
  p_reset_r1: assert property (@(posedge clk)
    !rst_n |=> (lvl_out == '0 && irq_out == '0));

  // R6: no write at the register leaves outputs unchanged
  p_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr[ADDR_W-1:1] == (ADDR_W-1)'(OFF_WORD))
      |=> $stable(lvl_out));

  // R7: odd lane alone is not a command
  p_lane_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_be == 2'b01) |=> $stable(lvl_out));

endmodule

// File: tb/sim_irq_level_drv.sv
`timescale 1ns/1ps
module sim_irq_level_drv;
  localparam int NP = 4;
  localparam int LW = 3;
  localparam int AW = 6;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           wr_en = 1'b0;
  logic [AW-1:0]  wr_addr = '0;
  logic [1:0]     wr_be = '0;
  logic [15:0]    wr_data = '0;
  logic [NP*LW-1:0] lvl_out;
  logic [NP-1:0]  irq_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [LW-1:0] exp_lvl [NP];

  always #2.5 clk = ~clk;

  irq_level_drv #(.NPORT(NP), .LVL_W(LW), .ADDR_W(AW), .REG_OFFSET(8)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_be(wr_be), .wr_data(wr_data), .lvl_out(lvl_out), .irq_out(irq_out)
  );

  task automatic check_all(input string req);
    logic [NP*LW-1:0] ev;
    logic [NP-1:0]    ei;
    for (int i = 0; i < NP; i++) begin
      ev[i*LW +: LW] = exp_lvl[i];
      ei[i]          = (exp_lvl[i] != 0);
    end
    checks++;
    if (lvl_out !== ev) begin
      fails++;
      $display("FAIL %s lvl_out=%h expected=%h", req, lvl_out, ev);
    end
    checks++;
    if (irq_out !== ei) begin
      fails++;
      $display("FAIL R8 (%s) irq_out=%b expected=%b", req, irq_out, ei);
    end
  endtask

  task automatic wr(input int en, input int addr, input logic [1:0] be,
                    input logic [15:0] d);
    @(negedge clk);
    wr_en = (en != 0); wr_addr = AW'(addr); wr_be = be; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (en != 0 && (addr / 2) == 4 && be[1] && int'(d[15:8]) < NP)
      exp_lvl[d[15:8]] = be[0] ? d[LW-1:0] : '0;
  endtask

  initial begin
    for (int i = 0; i < NP; i++) exp_lvl[i] = '0;
    repeat (3) @(negedge clk);
    check_all("R1 during reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 after reset");

    wr(1, 8, 2'b11, 16'h0102);
    check_all("R2 example 0x0102");

    for (int p = 0; p < 2*NP; p++)
      for (int l = 0; l < 16; l++) begin
        wr(1, 8, 2'b11, {8'(p), 8'(l)});
        if (p >= NP)        check_all("R5 out-of-range line");
        else if (l >= 8)    check_all("R9 truncated level");
        else                check_all("R2 sweep");
      end

    wr(1, 8, 2'b11, 16'h0105);
    wr(1, 9, 2'b11, 16'h0203);
    check_all("R2 odd address alias");
    repeat (5) @(negedge clk);
    check_all("R4 hold over idle cycles");
    wr(1, 8, 2'b11, 16'h0306);
    check_all("R4 other line written");

    wr(1, 8, 2'b10, 16'h0107);
    check_all("R3 single byte drives zero");

    wr(1, 8, 2'b11, 16'h0006);
    for (int a = 0; a < (1 << AW); a++)
      if (a / 2 != 4) begin
        wr(1, a, 2'b11, 16'h0001);
        check_all("R6 other address");
      end
    wr(0, 8, 2'b11, 16'h0001);
    check_all("R6 strobe low");

    wr(1, 8, 2'b01, 16'h0001);
    check_all("R7 odd lane only");
    wr(1, 8, 2'b00, 16'h0001);
    check_all("R7 no lane");

    rst_n = 1'b0;
    @(negedge clk);
    for (int i = 0; i < NP; i++) exp_lvl[i] = '0;
    check_all("R1 re-reset");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule